// File: doc/BRIEF.md
# VFD Multiplexed Grid Scanner with Key Matrix Capture

This block drives a vacuum fluorescent display by time multiplexing. It lights one grid at a time and presents that grid's segment pattern, which it reads from an external display memory. The memory is addressed by the grid index and returns its data in the same cycle. Every state change is gated by a slow `tick_i` strobe. A grid period holds eight sub-slots followed by one blanking slot. The dim level sets how many of the eight sub-slots have the grid enabled. The configured digit count sets how many grids make up one display cycle, from 8 to 16. Grids above eight are driven on eight shared pins. Any shared pin that is not needed as a grid drives an upper segment bit instead.

After the last grid's blanking slot, the block runs a key scan. It strobes the twelve dedicated segment lines one at a time as key sources and samples two key return lines into a shadow matrix. The shadow matrix is moved into the visible key snapshot only when the display cycle ends. The digit count and dim level are captured at the same point, so they stay fixed for the whole next cycle. A one-clock flag reports that the new snapshot differs from the old one.

The controller has four states:
- COMMIT ends a display cycle.
- LIT covers the active sub-slots of one grid.
- BLANK is the gap after each grid.
- KEYSCAN covers the source strobes.

It has five transitions, each taken on a tick:
- COMMIT→LIT: start a new cycle at grid 0.
- LIT→BLANK: after sub-slot 7.
- BLANK→LIT: move on to the next grid.
- BLANK→KEYSCAN: after the last grid.
- KEYSCAN→COMMIT: after source 11.

Top module: `vfd_scan_top`

## Requirements
- R1: While reset is held, `seg_o`, `shared_o`, `grid_o`, `key_matrix_o` and `key_chg_o` are all zero, and the controller sits in COMMIT.
- R2: The grid count of a display cycle is 8 plus `cfg_digits_i`, with any value above 8 taken as 8. The value is sampled only at the tick that leaves COMMIT, and a change made later in the cycle has no effect. Grids are scanned in ascending order from 0.
- R3: Each grid g spends eight ticks in LIT, at sub-slots 0 to 7. The grid is enabled during sub-slots 0 to `cfg_dim_i` inclusive, so dim 0 gives one slot and dim 7 gives all eight. The dim value is sampled together with the digit count.
- R4: Every LIT period is followed by one BLANK tick in which `seg_o`, `shared_o` and `grid_o` are all zero.
- R5: At most one grid output, counting `grid_o` and shared pins in grid mode, is high at any time. `grid_o[g]` is grid g for g below 8.
- R6: Shared pin k is grid 8+k when 8+k is below the grid count. Otherwise, during LIT it drives memory bit 12+k of the addressed grid, and it is zero in all other states.
- R7: During LIT, `mem_addr_o` equals the grid index and `seg_o` equals memory bits 11 to 0.
- R8: After the last BLANK, KEYSCAN lasts twelve ticks, one per source s from 0 to 11. During source s, `seg_o` equals 1<<s and all grids and shared pins are low. Return line r is sampled at the tick that ends source s and stored as key bit r*12+s.
- R9: `key_matrix_o` changes only in the clock after the tick that leaves COMMIT. It then shows the matrix captured in the preceding key scan.
- R10: `key_chg_o` is high for exactly the one clock after that commit tick, and only if the committed matrix differs from the previous snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slot advance strobe, one clock wide |
| cfg_digits_i | input | 4 | Extra grids above 8 (0 to 8, values above 8 clamp to 8) |
| cfg_dim_i | input | 3 | Dim level, 0 dimmest to 7 brightest |
| mem_addr_o | output | 4 | Display memory read address (grid index) |
| mem_rdata_i | input | 20 | Segment bits of the addressed grid, same-cycle read |
| key_ret_i | input | 2 | Key matrix return lines |
| seg_o | output | 12 | Dedicated segment lines, also key source strobes |
| shared_o | output | 8 | Shared segment/grid lines (grid 8+k or segment 12+k) |
| grid_o | output | 8 | Dedicated grid lines 0 to 7 |
| key_matrix_o | output | 24 | Committed key snapshot, bit r*12+s |
| key_chg_o | output | 1 | One-clock pulse when the committed snapshot changed |

## Verification
The tick that leaves COMMIT does three things in the same cycle: it commits the key shadow, raises the change flag, and captures the digit count and dim level that shape the grids that follow. The bench changes the configuration and the pressed-key pattern exactly in the COMMIT slot. It then inverts both configuration inputs in the first LIT slot of grid 0. This shows that the committed snapshot, the change pulse in the next clock, and the grid count of the new cycle all follow the values that were present at that single tick. Each slot is judged against a queued expectation, and the change flag is judged against the previous snapshot on the clock right after the commit.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    // Controller states; COMMIT is also the reset state.
    typedef enum logic [1:0] {
        ST_COMMIT  = 2'd0,
        ST_LIT     = 2'd1,
        ST_BLANK   = 2'd2,
        ST_KEYSCAN = 2'd3
    } scan_state_e;

endpackage

// File: rtl/vfd_scan_seq.sv
module vfd_scan_seq
    import vfd_scan_pkg::*;
#(
    parameter int GRID_BASE = 8,
    parameter int SEG_SHR   = 8,
    parameter int SEG_DED   = 12,
    parameter int SUB_SLOTS = 8,
    parameter int CFG_W     = 4,
    parameter int DIM_W     = 3,
    parameter int GIDX_W    = 4,
    parameter int KIDX_W    = 4,
    parameter int NG_W      = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [CFG_W-1:0]  cfg_digits_i,
    input  logic [DIM_W-1:0]  cfg_dim_i,
    output scan_state_e       state_o,
    output logic [GIDX_W-1:0] grid_o,
    output logic [DIM_W-1:0]  sub_o,
    output logic [KIDX_W-1:0] key_o,
    output logic [NG_W-1:0]   ngrid_o,
    output logic [DIM_W-1:0]  dim_o
);

    scan_state_e       state_q, state_d;
    logic [GIDX_W-1:0] grid_q, grid_d;
    logic [DIM_W-1:0]  sub_q, sub_d;
    logic [KIDX_W-1:0] key_q, key_d;
    logic [NG_W-1:0]   ngrid_q, ngrid_d;
    logic [DIM_W-1:0]  dim_q, dim_d;
    logic [NG_W-1:0]   extra;
    logic              last_grid;

    // Clamp the extra-grid request to the number of shared pins.
    assign extra     = (int'(cfg_digits_i) >= SEG_SHR) ? NG_W'(SEG_SHR)
                                                       : NG_W'(cfg_digits_i);
    assign last_grid = (NG_W'(grid_q) == (ngrid_q - NG_W'(1)));

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_COMMIT;
            grid_q  <= '0;
            sub_q   <= '0;
            key_q   <= '0;
            ngrid_q <= NG_W'(GRID_BASE);
            dim_q   <= '0;
        end else begin
            state_q <= state_d;
            grid_q  <= grid_d;
            sub_q   <= sub_d;
            key_q   <= key_d;
            ngrid_q <= ngrid_d;
            dim_q   <= dim_d;
        end
    end

    // Next-state logic; nothing moves without a tick.
    always_comb begin
        state_d = state_q;
        grid_d  = grid_q;
        sub_d   = sub_q;
        key_d   = key_q;
        ngrid_d = ngrid_q;
        dim_d   = dim_q;
        if (tick_i) begin
            unique case (state_q)
                ST_COMMIT: begin
                    ngrid_d = NG_W'(GRID_BASE) + extra;
                    dim_d   = cfg_dim_i;
                    grid_d  = '0;
                    sub_d   = '0;
                    state_d = ST_LIT;
                end
                ST_LIT: begin
                    if (sub_q == DIM_W'(SUB_SLOTS - 1)) begin
                        state_d = ST_BLANK;
                    end else begin
                        sub_d = sub_q + DIM_W'(1);
                    end
                end
                ST_BLANK: begin
                    sub_d = '0;
                    if (last_grid) begin
                        key_d   = '0;
                        state_d = ST_KEYSCAN;
                    end else begin
                        grid_d  = grid_q + GIDX_W'(1);
                        state_d = ST_LIT;
                    end
                end
                ST_KEYSCAN: begin
                    if (key_q == KIDX_W'(SEG_DED - 1)) begin
                        state_d = ST_COMMIT;
                    end else begin
                        key_d = key_q + KIDX_W'(1);
                    end
                end
                default: state_d = ST_COMMIT;
            endcase
        end
    end

    assign state_o = state_q;
    assign grid_o  = grid_q;
    assign sub_o   = sub_q;
    assign key_o   = key_q;
    assign ngrid_o = ngrid_q;
    assign dim_o   = dim_q;

endmodule

// File: rtl/vfd_drive_mux.sv
module vfd_drive_mux
    import vfd_scan_pkg::*;
#(
    parameter int SEG_DED   = 12,
    parameter int SEG_SHR   = 8,
    parameter int GRID_BASE = 8,
    parameter int MEM_W     = 20,
    parameter int DIM_W     = 3,
    parameter int GIDX_W    = 4,
    parameter int KIDX_W    = 4,
    parameter int NG_W      = 5
) (
    input  scan_state_e        state_i,
    input  logic [GIDX_W-1:0]  grid_i,
    input  logic [DIM_W-1:0]   sub_i,
    input  logic [KIDX_W-1:0]  key_i,
    input  logic [NG_W-1:0]    ngrid_i,
    input  logic [DIM_W-1:0]   dim_i,
    input  logic [MEM_W-1:0]   mem_rdata_i,
    output logic [SEG_DED-1:0] seg_o,
    output logic [SEG_SHR-1:0] shared_o,
    output logic [GRID_BASE-1:0] grid_o
);

    logic in_lit;
    logic lit_win;

    assign in_lit  = (state_i == ST_LIT);
    assign lit_win = in_lit && (sub_i <= dim_i);

    // Dedicated segment and grid lines.
    always_comb begin
        seg_o  = '0;
        grid_o = '0;
        unique case (state_i)
            ST_LIT: begin
                seg_o = mem_rdata_i[SEG_DED-1:0];
                // Indices at or above GRID_BASE shift out to zero.
                if (lit_win) begin
                    grid_o = GRID_BASE'(1) << grid_i;
                end
            end
            ST_KEYSCAN: seg_o = SEG_DED'(1) << key_i;
            ST_BLANK:   seg_o = '0;
            ST_COMMIT:  seg_o = '0;
            default:    seg_o = '0;
        endcase
    end

    // Shared pins: the grid count selects grid or segment duty per pin.
    for (genvar k = 0; k < SEG_SHR; k++) begin : g_shared
        logic as_grid;
        assign as_grid = (NG_W'(GRID_BASE + k) < ngrid_i);
        assign shared_o[k] = as_grid
            ? (lit_win && (grid_i == GIDX_W'(GRID_BASE + k)))
            : (in_lit && mem_rdata_i[SEG_DED + k]);
    end

endmodule

// File: rtl/vfd_key_store.sv
module vfd_key_store
    import vfd_scan_pkg::*;
#(
    parameter int KEY_RET = 2,
    parameter int SEG_DED = 12,
    parameter int KIDX_W  = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tick_i,
    input  scan_state_e          state_i,
    input  logic [KIDX_W-1:0]    key_i,
    input  logic [KEY_RET-1:0]   ret_i,
    output logic [KEY_RET*SEG_DED-1:0] matrix_o,
    output logic                 chg_o
);

    logic [KEY_RET-1:0][SEG_DED-1:0] shadow_q;
    logic [KEY_RET-1:0][SEG_DED-1:0] snap_q;
    logic                            chg_q;
    logic                            scan_en;
    logic                            commit_en;

    assign scan_en   = tick_i && (state_i == ST_KEYSCAN);
    assign commit_en = tick_i && (state_i == ST_COMMIT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shadow_q <= '0;
            snap_q   <= '0;
            chg_q    <= 1'b0;
        end else begin
            chg_q <= 1'b0;
            if (scan_en) begin
                for (int r = 0; r < KEY_RET; r++) begin
                    shadow_q[r][key_i] <= ret_i[r];
                end
            end
            if (commit_en) begin
                snap_q <= shadow_q;
                chg_q  <= (shadow_q != snap_q);
            end
        end
    end

    assign matrix_o = snap_q;
    assign chg_o    = chg_q;

endmodule

// File: rtl/vfd_scan_top.sv
module vfd_scan_top
    import vfd_scan_pkg::*;
#(
    parameter int SEG_DED   = 12,
    parameter int SEG_SHR   = 8,
    parameter int GRID_BASE = 8,
    parameter int KEY_RET   = 2,
    parameter int SUB_SLOTS = 8,
    localparam int MAX_GRIDS = GRID_BASE + SEG_SHR,
    localparam int GIDX_W    = $clog2(MAX_GRIDS),
    localparam int MEM_W     = SEG_DED + SEG_SHR,
    localparam int KIDX_W    = $clog2(SEG_DED),
    localparam int KEY_BITS  = KEY_RET * SEG_DED,
    localparam int CFG_W     = $clog2(SEG_SHR + 1),
    localparam int NG_W      = $clog2(MAX_GRIDS + 1),
    localparam int DIM_W     = $clog2(SUB_SLOTS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tick_i,
    input  logic [CFG_W-1:0]     cfg_digits_i,
    input  logic [DIM_W-1:0]     cfg_dim_i,
    output logic [GIDX_W-1:0]    mem_addr_o,
    input  logic [MEM_W-1:0]     mem_rdata_i,
    input  logic [KEY_RET-1:0]   key_ret_i,
    output logic [SEG_DED-1:0]   seg_o,
    output logic [SEG_SHR-1:0]   shared_o,
    output logic [GRID_BASE-1:0] grid_o,
    output logic [KEY_BITS-1:0]  key_matrix_o,
    output logic                 key_chg_o
);

    scan_state_e       scan_state;
    logic [GIDX_W-1:0] grid_idx;
    logic [DIM_W-1:0]  sub_idx;
    logic [KIDX_W-1:0] key_idx;
    logic [NG_W-1:0]   ngrid;
    logic [DIM_W-1:0]  dim_lvl;

    vfd_scan_seq #(
        .GRID_BASE (GRID_BASE),
        .SEG_SHR   (SEG_SHR),
        .SEG_DED   (SEG_DED),
        .SUB_SLOTS (SUB_SLOTS),
        .CFG_W     (CFG_W),
        .DIM_W     (DIM_W),
        .GIDX_W    (GIDX_W),
        .KIDX_W    (KIDX_W),
        .NG_W      (NG_W)
    ) u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick_i),
        .cfg_digits_i (cfg_digits_i),
        .cfg_dim_i    (cfg_dim_i),
        .state_o      (scan_state),
        .grid_o       (grid_idx),
        .sub_o        (sub_idx),
        .key_o        (key_idx),
        .ngrid_o      (ngrid),
        .dim_o        (dim_lvl)
    );

    vfd_drive_mux #(
        .SEG_DED   (SEG_DED),
        .SEG_SHR   (SEG_SHR),
        .GRID_BASE (GRID_BASE),
        .MEM_W     (MEM_W),
        .DIM_W     (DIM_W),
        .GIDX_W    (GIDX_W),
        .KIDX_W    (KIDX_W),
        .NG_W      (NG_W)
    ) u_mux (
        .state_i     (scan_state),
        .grid_i      (grid_idx),
        .sub_i       (sub_idx),
        .key_i       (key_idx),
        .ngrid_i     (ngrid),
        .dim_i       (dim_lvl),
        .mem_rdata_i (mem_rdata_i),
        .seg_o       (seg_o),
        .shared_o    (shared_o),
        .grid_o      (grid_o)
    );

    vfd_key_store #(
        .KEY_RET (KEY_RET),
        .SEG_DED (SEG_DED),
        .KIDX_W  (KIDX_W)
    ) u_keys (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .state_i  (scan_state),
        .key_i    (key_idx),
        .ret_i    (key_ret_i),
        .matrix_o (key_matrix_o),
        .chg_o    (key_chg_o)
    );

    assign mem_addr_o = grid_idx;

endmodule

// File: rtl/vfd_scan_chk.sv
module vfd_scan_chk
    import vfd_scan_pkg::*;
#(
    parameter int SEG_DED   = 12,
    parameter int SEG_SHR   = 8,
    parameter int GRID_BASE = 8,
    parameter int KEY_BITS  = 24,
    parameter int DIM_W     = 3
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 tick_i,
    input scan_state_e          state_i,
    input logic [DIM_W-1:0]     sub_i,
    input logic [DIM_W-1:0]     dim_i,
    input logic [SEG_DED-1:0]   seg_i,
    input logic [SEG_SHR-1:0]   shared_i,
    input logic [GRID_BASE-1:0] grid_i,
    input logic [KEY_BITS-1:0]  matrix_i,
    input logic                 chg_i
);

    // R5
    grid_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grid_i));

    // R3
    dim_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grid_i != '0) |-> (sub_i <= dim_i));

    // R4
    blank_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_BLANK) |-> ((grid_i == '0) && (seg_i == '0) && (shared_i == '0)));

    // R8
    strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_KEYSCAN) |-> (($countones(seg_i) == 1) && (grid_i == '0) && (shared_i == '0)));

    // R9
    matrix_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(matrix_i) |-> $past((state_i == ST_COMMIT) && tick_i));

    // R10
    chg_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chg_i |=> !chg_i);

endmodule

bind vfd_scan_top vfd_scan_chk #(
    .SEG_DED   (SEG_DED),
    .SEG_SHR   (SEG_SHR),
    .GRID_BASE (GRID_BASE),
    .KEY_BITS  (KEY_BITS),
    .DIM_W     (DIM_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .state_i  (scan_state),
    .sub_i    (sub_idx),
    .dim_i    (dim_lvl),
    .seg_i    (seg_o),
    .shared_i (shared_o),
    .grid_i   (grid_o),
    .matrix_i (key_matrix_o),
    .chg_i    (key_chg_o)
);

// File: tb/tb_vfd_scan_top.sv
`timescale 1ns/1ps
module tb_vfd_scan_top;

    logic        clk_i = 1'b0;
    logic        rst_ni;
    logic        tick_i;
    logic [3:0]  cfg_digits_i;
    logic [2:0]  cfg_dim_i;
    logic [3:0]  mem_addr_o;
    logic [19:0] mem_rdata_i;
    logic [1:0]  key_ret_i;
    logic [11:0] seg_o;
    logic [7:0]  shared_o;
    logic [7:0]  grid_o;
    logic [23:0] key_matrix_o;
    logic        key_chg_o;

    always #2 clk_i = ~clk_i;

    logic [19:0] mem [16];
    logic [23:0] pressed;

    // Display memory model and key switch matrix model.
    assign mem_rdata_i  = mem[mem_addr_o];
    assign key_ret_i[0] = |(seg_o & pressed[11:0]);
    assign key_ret_i[1] = |(seg_o & pressed[23:12]);

    vfd_scan_top dut (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick_i),
        .cfg_digits_i (cfg_digits_i),
        .cfg_dim_i    (cfg_dim_i),
        .mem_addr_o   (mem_addr_o),
        .mem_rdata_i  (mem_rdata_i),
        .key_ret_i    (key_ret_i),
        .seg_o        (seg_o),
        .shared_o     (shared_o),
        .grid_o       (grid_o),
        .key_matrix_o (key_matrix_o),
        .key_chg_o    (key_chg_o)
    );

    // kind: 0 commit, 1 lit, 2 blank, 3 key strobe
    typedef struct {
        int          kind;
        bit          scramble;
        logic [11:0] seg;
        logic [7:0]  shr;
        logic [7:0]  grd;
        logic [23:0] km;
        bit          chg;
        logic [3:0]  dig;
        logic [2:0]  dim;
        logic [23:0] prs;
    } slot_t;

    slot_t       q[$];
    logic [23:0] exp_km;
    logic [23:0] last_scan;
    int          checks;
    int          errors;
    bit          done;
    bit          timed_out;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, expv);
        end
    endtask

    // Driver: expands one display cycle into expected slots.
    task automatic gen_cycle(input logic [3:0] dig, input logic [2:0] dm, input logic [23:0] prs);
        slot_t it;
        int    ng;
        it.kind = 0; it.scramble = 0; it.seg = '0; it.shr = '0; it.grd = '0;
        it.km = exp_km; it.chg = (last_scan != exp_km);
        it.dig = dig; it.dim = dm; it.prs = prs;
        q.push_back(it);
        exp_km = last_scan;
        ng = 8 + ((dig > 4'd8) ? 8 : int'(dig));
        for (int g = 0; g < ng; g++) begin
            for (int s = 0; s < 9; s++) begin
                it.scramble = (g == 0 && s == 0);
                it.km  = exp_km;
                it.chg = 0;
                if (s == 8) begin
                    it.kind = 2; it.seg = '0; it.shr = '0; it.grd = '0;
                end else begin
                    it.kind = 1;
                    it.seg  = mem[g][11:0];
                    for (int k = 0; k < 8; k++) begin
                        it.shr[k] = (8 + k < ng) ? ((g == 8 + k) && (s <= int'(dm)))
                                                 : mem[g][12 + k];
                    end
                    it.grd = ((g < 8) && (s <= int'(dm))) ? 8'(1 << g) : 8'h00;
                end
                q.push_back(it);
            end
        end
        for (int i = 0; i < 12; i++) begin
            it.kind = 3; it.scramble = 0;
            it.seg = 12'(1 << i); it.shr = '0; it.grd = '0; it.km = exp_km;
            q.push_back(it);
        end
        last_scan = prs;
    endtask

    function automatic string kname(input int kind);
        case (kind)
            0:       return "R9 commit";
            1:       return "R2 R3 R5 R6 R7 lit";
            2:       return "R4 blank";
            default: return "R8 strobe";
        endcase
    endfunction

    // Tick generator: one clock high, one low.
    initial begin
        tick_i = 1'b0;
        wait (rst_ni === 1'b1);
        forever @(negedge clk_i) tick_i <= ~tick_i;
    end

    // Monitor: pops and compares on the last clock of each slot.
    initial begin : monitor
        slot_t it;
        bit    chg_due;
        bit    chg_exp;
        chg_due = 0;
        chg_exp = 0;
        wait (rst_ni === 1'b1);
        while (q.size() > 0) begin
            @(negedge clk_i);
            #1;
            if (chg_due) begin
                chk("R10 change pulse", 32'(key_chg_o), 32'(chg_exp));
                chg_due = 0;
            end else if (key_chg_o !== 1'b0) begin
                chk("R10 stray pulse", 32'(key_chg_o), 32'd0);
            end
            if (tick_i) begin
                it = q.pop_front();
                chk({kname(it.kind), " seg"}, 32'(seg_o), 32'(it.seg));
                chk({kname(it.kind), " shared"}, 32'(shared_o), 32'(it.shr));
                chk({kname(it.kind), " grid"}, 32'(grid_o), 32'(it.grd));
                chk("R9 key matrix", 32'(key_matrix_o), 32'(it.km));
                if (it.kind == 0) begin
                    cfg_digits_i = it.dig;
                    cfg_dim_i    = it.dim;
                    pressed      = it.prs;
                    chg_due      = 1;
                    chg_exp      = it.chg;
                end
                if (it.scramble) begin
                    // R2: mid-cycle change must be ignored
                    cfg_digits_i = ~cfg_digits_i;
                    cfg_dim_i    = ~cfg_dim_i;
                end
            end
        end
        done = 1;
    end

    // Watchdog.
    initial begin
        timed_out = 0;
        repeat (100000) @(posedge clk_i);
        timed_out = 1;
    end

    initial begin
        logic [31:0] h;
        checks = 0; errors = 0; done = 0;
        exp_km = '0; last_scan = '0; pressed = '0;
        cfg_digits_i = '0; cfg_dim_i = '0;
        for (int g = 0; g < 16; g++) begin
            h = 32'h9E3779B1 * 32'(g + 1);
            mem[g] = h[31:12] ^ 20'h5A5A5;
        end
        gen_cycle(4'd0,  3'd7, 24'h000000);
        gen_cycle(4'd8,  3'd0, 24'h800801);
        gen_cycle(4'd3,  3'd3, 24'h800801);
        gen_cycle(4'd15, 3'd5, 24'hFFFFFF);
        gen_cycle(4'd1,  3'd0, 24'h05A0F3);
        gen_cycle(4'd5,  3'd6, 24'h000000);

        rst_ni = 1'b0;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        #1;
        // R1: quiet outputs while reset is held
        chk("R1 reset seg", 32'(seg_o), 32'd0);
        chk("R1 reset shared", 32'(shared_o), 32'd0);
        chk("R1 reset grid", 32'(grid_o), 32'd0);
        chk("R1 reset keys", 32'(key_matrix_o), 32'd0);
        chk("R1 reset chg", 32'(key_chg_o), 32'd0);
        rst_ni = 1'b1;

        wait (done || timed_out);
        if (timed_out && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule